// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a small serial EEPROM of 256 sixteen-bit words that software drives by bit-banging. Each time the CPU writes its control register, the block receives new levels for chip select, serial clock and data-in. It compares those levels with the ones it holds from the previous write and acts only on edges. One returned bit carries the data-out line. The CPU wrapper and any non-volatile backing are outside the block.

A transaction begins with a chip-select rising edge, which moves the machine from NULL to IDLE. A serial-clock rising edge with data-in high is the start bit (IDLE to OPC). Two opcode bits follow (OPC to ADDR), then eight address bits. The opcode then selects the next state: CTRL for 00, WDATA for 01, RDUMMY for 10 and EDATA for 11. Data-in bits shift into a 17-bit shift register on clock rising edges in every state except NULL, IDLE and READ. A write, an erase or a fill ends in WPEND. There a chip-select rising edge stores the low 16 shift bits at the latched address, sets the shift register to all ones and returns to NULL. In any other state, a chip-select rising edge only moves the machine to IDLE. A read loads the addressed word into RDUMMY and moves to READ, where each clock falling edge shifts one bit out. After sixteen falling edges the machine is back in NULL.

The two fill commands, write-all and erase-all, step through every word in 256 consecutive cycles. During that time data-out is held low as a busy flag and register writes are ignored.

Top module: `ee3w_slave`

## Requirements
- R1: After reset, data-out is 1 (the shift register holds all ones), the state is NULL and writes are disabled, so a write command followed by a commit changes no stored word.
- R2: In NULL, serial-clock edges have no effect: a full command clocked in without a chip-select rising edge changes no stored word. A chip-select rising edge outside WPEND moves the machine to IDLE.
- R3: In IDLE, clock rising edges with data-in 0 are ignored. The first rising edge with data-in 1 is the start bit.
- R4: Opcode 00 with address bits [7:6] = 11 enables writes, and with [7:6] = 00 disables them. Either takes effect at the eighth address bit.
- R5: Opcode 01 followed by 16 data bits (MSB first), then a chip-select rising edge, stores the data at the address when writes are enabled. Data-out is 1 after the commit.
- R6: When writes are disabled, a commit leaves memory unchanged.
- R7: Opcode 11 followed by 16 bits, then a commit, stores 0xFFFF at the address when writes are enabled.
- R8: Opcode 10 takes one dummy clock rising edge, after which data-out is 0. Each of the next 16 clock falling edges presents the next word bit on data-out, from bit 15 down to bit 0.
- R9: Opcode 00 with [7:6] = 01 and 16 data bits writes those data to all 256 words. With [7:6] = 10 it writes 0xFFFF to all words. Either fill happens only when writes are enabled.
- R10: A fill takes 256 cycles. During it data-out is 0 and register writes (including a chip-select rising edge) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_we | input | 1 | One-cycle strobe: the CPU wrote the control register |
| pin_cs | input | 1 | Chip-select level carried by the write |
| pin_sk | input | 1 | Serial-clock level carried by the write |
| pin_di | input | 1 | Data-in level carried by the write |
| dout | output | 1 | Data-out: bit 16 of the shift register, or 0 while a fill runs |

## Verification
The assertions assume software never changes chip select and serial clock in the same register write in a way that depends on the order in which they are handled. They also assume a strobe lasts a single cycle. The stimulus moves only one of these lines per write, and it always returns chip select low before raising it again. Random traffic mixes writes, erases and read-backs at random addresses and with random data. It never issues a new command while a fill is still stepping, except for the deliberate strobes that check the busy window is ignored.

// File: rtl/ee_pkg.sv
package ee_pkg;

    typedef enum logic [3:0] {
        S_NULL,
        S_IDLE,
        S_OPC,
        S_ADDR,
        S_CTRL,
        S_WDATA,
        S_RDUMMY,
        S_EDATA,
        S_READ,
        S_WPEND
    } ee_state_t;

    localparam logic [1:0] OP_CTRL  = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] SUB_LOCK  = 2'b00;
    localparam logic [1:0] SUB_FILLD = 2'b01;
    localparam logic [1:0] SUB_FILLE = 2'b10;
    localparam logic [1:0] SUB_OPEN  = 2'b11;

endpackage

// File: rtl/ee_pin_edge.sv
module ee_pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic cs,
    input  logic sk,
    output logic cs_rise,
    output logic sk_rise,
    output logic sk_fall
);
    logic cs_q;
    logic sk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= 1'b0;
            sk_q <= 1'b0;
        end else if (accept) begin
            cs_q <= cs;
            sk_q <= sk;
        end
    end

    always_comb begin
        cs_rise = accept &  cs & ~cs_q;
        sk_rise = accept &  sk & ~sk_q;
        sk_fall = accept & ~sk &  sk_q;
    end

endmodule

// File: rtl/ee_word_store.sv
module ee_word_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fill_start,
    input  logic [DATA_W-1:0] fill_val,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    output logic              busy
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] fill_q;
    logic [ADDR_W-1:0] cnt_q;
    logic              busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            fill_q <= '0;
        end else if (fill_start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            fill_q <= fill_val;
        end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (&cnt_q) begin
                busy_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (busy_q) begin
            mem[cnt_q] <= fill_q;
        end else if (wr_req) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rd_word = mem[rd_addr];
        busy    = busy_q;
    end

    // R10: the fill window ends right after the last word
    a_r10_fill_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && (&cnt_q)) |=> !busy_q);

    // R10: the command side raises no single-word write while stepping
    a_r10_no_commit_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !wr_req);

endmodule

// File: rtl/ee_cmd_fsm.sv
module ee_cmd_fsm
    import ee_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_rise,
    input  logic              sk_rise,
    input  logic              sk_fall,
    input  logic              di,
    input  logic [DATA_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              fill_start,
    output logic [DATA_W-1:0] fill_val,
    output logic              sr_msb
);
    localparam int SR_W  = DATA_W + 1;
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int OPC_W = 2;

    ee_state_t         st_q, st_m, st_n;
    logic [SR_W-1:0]   sr_q, sr_n;
    logic [CNT_W-1:0]  bits_q, bits_n;
    logic [OPC_W-1:0]  cmd_q, cmd_n;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic              wen_q, wen_n;
    logic [1:0]        sub;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_NULL;
            sr_q   <= '1;
            bits_q <= '0;
            cmd_q  <= '0;
            addr_q <= '0;
            wen_q  <= 1'b0;
        end else begin
            st_q   <= st_n;
            sr_q   <= sr_n;
            bits_q <= bits_n;
            cmd_q  <= cmd_n;
            addr_q <= addr_n;
            wen_q  <= wen_n;
        end
    end

    // next state
    always_comb begin
        st_m       = st_q;
        sr_n       = sr_q;
        bits_n     = bits_q;
        cmd_n      = cmd_q;
        addr_n     = addr_q;
        wen_n      = wen_q;
        wr_req     = 1'b0;
        fill_start = 1'b0;
        fill_val   = '1;
        sub        = addr_q[ADDR_W-1 -: 2];

        if (cs_rise) begin
            if (st_q == S_WPEND) begin
                wr_req = wen_q;
                sr_n   = '1;
                st_m   = S_NULL;
            end else begin
                st_m   = S_IDLE;
            end
        end
        st_n = st_m;

        if (sk_rise) begin
            if (st_m != S_NULL && st_m != S_IDLE && st_m != S_READ) begin
                sr_n   = {sr_n[SR_W-2:0], di};
                bits_n = bits_q + 1'b1;
            end
            unique case (st_m)
                S_IDLE: begin
                    if (di) begin
                        st_n   = S_OPC;
                        sr_n   = '0;
                        bits_n = '0;
                    end
                end
                S_OPC: begin
                    if (bits_n == CNT_W'(OPC_W)) begin
                        st_n   = S_ADDR;
                        bits_n = '0;
                        cmd_n  = sr_n[OPC_W-1:0];
                    end
                end
                S_ADDR: begin
                    if (bits_n == CNT_W'(ADDR_W)) begin
                        bits_n = '0;
                        addr_n = sr_n[ADDR_W-1:0];
                        sub    = sr_n[ADDR_W-1 -: 2];
                        unique case (cmd_q)
                            OP_CTRL: begin
                                st_n = S_CTRL;
                                if (sub == SUB_LOCK) begin
                                    wen_n = 1'b0;
                                    st_n  = S_NULL;
                                end else if (sub == SUB_OPEN) begin
                                    wen_n = 1'b1;
                                    st_n  = S_NULL;
                                end
                            end
                            OP_WRITE: st_n = S_WDATA;
                            OP_READ:  st_n = S_RDUMMY;
                            OP_ERASE: st_n = S_EDATA;
                        endcase
                    end
                end
                S_CTRL: begin
                    if (bits_n == CNT_W'(DATA_W)) begin
                        if (sub == SUB_FILLD) begin
                            st_n       = S_WPEND;
                            fill_start = wen_q;
                            fill_val   = sr_n[DATA_W-1:0];
                        end else if (sub == SUB_FILLE) begin
                            st_n       = S_WPEND;
                            fill_start = wen_q;
                        end
                    end
                end
                S_WDATA: begin
                    if (bits_n == CNT_W'(DATA_W)) begin
                        bits_n = '0;
                        st_n   = S_WPEND;
                    end
                end
                S_RDUMMY: begin
                    if (bits_n == CNT_W'(1)) begin
                        sr_n   = {1'b0, rd_word};
                        bits_n = '0;
                        st_n   = S_READ;
                    end
                end
                S_EDATA: begin
                    if (bits_n == CNT_W'(DATA_W)) begin
                        sr_n   = {1'b0, {DATA_W{1'b1}}};
                        bits_n = '0;
                        st_n   = S_WPEND;
                    end
                end
                S_NULL, S_READ, S_WPEND: begin
                end
            endcase
        end else if (sk_fall && st_m == S_READ) begin
            sr_n   = {sr_q[SR_W-2:0], 1'b0};
            bits_n = bits_q + 1'b1;
            if (bits_n == CNT_W'(DATA_W)) begin
                bits_n = '0;
                st_n   = S_NULL;
            end
        end
    end

    // outputs
    always_comb begin
        rd_addr = addr_q;
        wr_addr = addr_q;
        wr_data = sr_q[DATA_W-1:0];
        sr_msb  = sr_q[SR_W-1];
    end

    // R5: a commit returns to NULL with the shift register all ones
    a_r5_commit_to_null: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && st_q == S_WPEND) |=> (st_q == S_NULL && sr_q == {SR_W{1'b1}}));

    // R2: NULL is left only through a chip-select rising edge
    a_r2_null_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_NULL && !cs_rise) |=> st_q == S_NULL);

    // R8: in READ the shift register moves only on a falling clock edge
    a_r8_read_shift_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_READ && !sk_fall && !cs_rise) |=> $stable(sr_q));

    // R4: the enable flag changes only on a clock rising edge
    a_r4_wen_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !sk_rise |=> $stable(wen_q));

endmodule

// File: rtl/ee3w_slave.sv
module ee3w_slave #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_we,
    input  logic pin_cs,
    input  logic pin_sk,
    input  logic pin_di,
    output logic dout
);
    logic              busy;
    logic              accept;
    logic              cs_rise, sk_rise, sk_fall;
    logic              wr_req, fill_start, sr_msb;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, fill_val, rd_word;

    assign accept = pin_we & ~busy;

    ee_pin_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .cs      (pin_cs),
        .sk      (pin_sk),
        .cs_rise (cs_rise),
        .sk_rise (sk_rise),
        .sk_fall (sk_fall)
    );

    ee_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_rise    (cs_rise),
        .sk_rise    (sk_rise),
        .sk_fall    (sk_fall),
        .di         (pin_di),
        .rd_word    (rd_word),
        .rd_addr    (rd_addr),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .fill_start (fill_start),
        .fill_val   (fill_val),
        .sr_msb     (sr_msb)
    );

    ee_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .fill_start (fill_start),
        .fill_val   (fill_val),
        .rd_addr    (rd_addr),
        .rd_word    (rd_word),
        .busy       (busy)
    );

    always_comb begin
        dout = busy ? 1'b0 : sr_msb;
    end

    // R10: no pin edge is seen while a fill is stepping
    a_r10_edges_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(cs_rise || sk_rise || sk_fall));

endmodule

// File: tb/sim_ee3w_slave.sv
`timescale 1ns/1ps
module sim_ee3w_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_we = 1'b0, pin_cs = 1'b0, pin_sk = 1'b0, pin_di = 1'b0;
    logic dout;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_mem [256];
    logic wen_m = 1'b0;

    always #2.5 clk = ~clk;

    ee3w_slave u0 (
        .clk(clk), .rst_n(rst_n), .pin_we(pin_we),
        .pin_cs(pin_cs), .pin_sk(pin_sk), .pin_di(pin_di), .dout(dout)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic cs, input logic sk, input logic di);
        @(negedge clk);
        pin_we = 1'b1; pin_cs = cs; pin_sk = sk; pin_di = di;
        @(negedge clk);
        pin_we = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        strobe(1'b1, 1'b0, b);
        strobe(1'b1, 1'b1, b);
    endtask

    task automatic begin_cmd(input logic [1:0] op, input logic [7:0] a);
        strobe(1'b0, 1'b0, 1'b0);
        strobe(1'b1, 1'b0, 1'b0);
        send_bit(1'b1);
        for (int i = 1; i >= 0; i--) send_bit(op[i]);
        for (int i = 7; i >= 0; i--) send_bit(a[i]);
    endtask

    task automatic send_word(input logic [15:0] d);
        for (int i = 15; i >= 0; i--) send_bit(d[i]);
    endtask

    task automatic commit(input string req);
        strobe(1'b0, 1'b0, 1'b0);
        strobe(1'b1, 1'b0, 1'b0);
        check(req, {31'd0, dout}, 32'd1);
    endtask

    function automatic logic [15:0] expect_word(input logic [7:0] a);
        return exp_mem[a];
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [15:0] d);
        begin_cmd(2'b01, a);
        send_word(d);
        commit("R5 dout after commit");
        if (wen_m) exp_mem[a] = d;
    endtask

    task automatic do_erase(input logic [7:0] a);
        begin_cmd(2'b11, a);
        send_word(16'h0000);
        commit("R7 dout after commit");
        if (wen_m) exp_mem[a] = 16'hFFFF;
    endtask

    task automatic do_read(input logic [7:0] a, input string req);
        logic [15:0] got;
        begin_cmd(2'b10, a);
        send_bit(1'b0);
        check("R8 dummy bit", {31'd0, dout}, 32'd0);
        for (int i = 15; i >= 0; i--) begin
            strobe(1'b1, 1'b0, 1'b0);
            got[i] = dout;
            strobe(1'b1, 1'b1, 1'b0);
        end
        check(req, {16'd0, got}, {16'd0, expect_word(a)});
    endtask

    task automatic set_wen(input logic en);
        begin_cmd(2'b00, en ? 8'hC0 : 8'h00);
        strobe(1'b0, 1'b0, 1'b0);
        wen_m = en;
    endtask

    task automatic do_fill(input logic erase, input logic [15:0] d);
        logic [15:0] v;
        v = erase ? 16'hFFFF : d;
        begin_cmd(2'b00, erase ? 8'h80 : 8'h40);
        send_word(v);
        check("R10 dout low at fill start", {31'd0, dout}, 32'd0);
        // R10: chip-select edge during the fill must be dropped
        strobe(1'b0, 1'b0, 1'b0);
        strobe(1'b1, 1'b0, 1'b0);
        check("R10 dout low while busy", {31'd0, dout}, 32'd0);
        repeat (300) @(negedge clk);
        check("R10 strobes ignored during fill", {31'd0, dout}, 32'd0);
        commit("R9 dout after fill commit");
        if (wen_m) for (int i = 0; i < 256; i++) exp_mem[i] = v;
    endtask

    task automatic apply_reset;
        @(negedge clk);
        rst_n = 1'b0; pin_we = 1'b0; pin_cs = 1'b0; pin_sk = 1'b0; pin_di = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wen_m = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        apply_reset();
        check("R1 dout after reset", {31'd0, dout}, 32'd1);

        // R9 erase-all establishes known contents
        set_wen(1'b1);
        do_fill(1'b1, 16'h0000);
        do_read(8'h05, "R9 erase-all word 05");
        do_read(8'hFE, "R9 erase-all word FE");

        // R6 protected write
        set_wen(1'b0);
        do_write(8'h05, 16'h1234);
        do_read(8'h05, "R6 protected write ignored");

        // R9 write-all
        set_wen(1'b1);
        do_fill(1'b0, 16'hA5C3);
        do_read(8'h00, "R9 write-all word 00");
        do_read(8'h77, "R9 write-all word 77");
        do_read(8'hFF, "R9 write-all word FF");

        // R5 boundary addresses
        do_write(8'h00, 16'h8001);
        do_write(8'hFF, 16'h7FFE);
        do_read(8'h00, "R5 write word 00");
        do_read(8'hFF, "R5 write word FF");

        // R7 erase one word
        do_erase(8'h07);
        do_read(8'h07, "R7 erase word 07");

        // R3 leading zeros before the start bit
        strobe(1'b0, 1'b0, 1'b0);
        strobe(1'b1, 1'b0, 1'b0);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b0); send_bit(1'b1);
        for (int i = 7; i >= 0; i--) send_bit(8'h3C >> i);
        send_word(16'h0F0F);
        commit("R3 commit after leading zeros");
        exp_mem[8'h3C] = 16'h0F0F;
        do_read(8'h3C, "R3 start bit after zeros");

        // R2 NULL ignores a command without a chip-select rising edge
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        for (int i = 7; i >= 0; i--) send_bit(8'h3C >> i);
        send_word(16'hDEAD);
        strobe(1'b1, 1'b0, 1'b0);
        check("R2 dout unchanged in NULL", {31'd0, dout}, 32'd1);
        do_read(8'h3C, "R2 NULL ignored command");

        // R4 disable then enable again
        set_wen(1'b0);
        do_erase(8'h3C);
        do_read(8'h3C, "R4 disable blocks erase");
        set_wen(1'b1);
        do_write(8'h3C, 16'h5A5A);
        do_read(8'h3C, "R4 enable allows write");

        // random traffic
        for (int n = 0; n < 40; n++) begin
            logic [7:0] a;
            int op;
            a  = 8'($urandom_range(0, 255));
            op = $urandom_range(0, 3);
            if (op == 0) do_erase(a);
            else if (op == 1) do_read(a, "R8 random read");
            else do_write(a, 16'($urandom_range(0, 65535)));
        end
        for (int n = 0; n < 10; n++) begin
            logic [7:0] a;
            a = 8'($urandom_range(0, 255));
            do_read(a, "R5 random read-back");
        end

        // R9 fills are blocked when writes are disabled
        set_wen(1'b0);
        begin_cmd(2'b00, 8'h40);
        send_word(16'h1111);
        commit("R9 blocked fill commit");
        do_read(8'h00, "R9 fill blocked when disabled");
        do_read(8'h3C, "R9 fill blocked when disabled 3C");

        // R1 writes disabled again after reset
        set_wen(1'b1);
        apply_reset();
        check("R1 dout after second reset", {31'd0, dout}, 32'd1);
        do_write(8'hFF, 16'h0000);
        do_read(8'hFF, "R1 writes disabled after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule